// File: doc/BRIEF.md
# Evicting Byte Queue with Early-Full Flag

This block is a circular byte queue placed between a character source and a reader that fetches one byte at a time. The source pushes a byte with a strobe. The reader pops with a strobe, and the popped byte shows up on a registered output one clock later. A synchronous clear empties the queue. The block reports its occupancy, an empty indication, and an early-full flag.

The source is never stalled. When a byte arrives and the queue is already at capacity, the oldest stored byte is thrown away to make room, and the new byte is kept. The early-full flag rises while spare room still remains: it is set whenever the free space is below a programmable slack. This lets a source that sends in fixed bursts stop before any eviction happens. Both the capacity and the slack are parameters. The capacity must be a power of two and larger than the slack. The pointers are log2(capacity) bits wide and wrap on their own.

Top module: `obf_byte_queue`

## Requirements
- R1: A push with occupancy below capacity stores the byte at the tail and raises `level` by one on the next clock.
- R2: A push with `level` equal to capacity and no pop discards the oldest byte. `level` stays at capacity, and later pops return the newest bytes in arrival order.
- R3: A pop with `level` nonzero places the oldest byte on `pop_data` one clock later and lowers `level` by one. Bytes leave in the order they arrived.
- R4: A pop with `level` zero places 8'hFF on `pop_data` one clock later and changes no occupancy. A push in the same cycle is still stored, so `level` becomes 1.
- R5: A push and a pop in the same cycle with `level` nonzero leave `level` unchanged, and the popped byte is the one stored before that cycle. At capacity, the pop delivers the oldest byte and nothing else is lost.
- R6: A clear sets `level` to 0 on the next clock. A clear takes priority over any push or pop in the same cycle, and `pop_data` keeps its value.
- R7: `nearly_full` is 1 exactly when capacity minus `level` is less than the slack. With the defaults (128, 64), this means `level` of 65 or more.
- R8: `empty` is 1 exactly when `level` is 0.
- R9: After reset, `level` is 0, `empty` is 1, `nearly_full` is 0 and `pop_data` is 8'hFF.
- R10: `pop_data` holds its value in every cycle without an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push | input | 1 | Push strobe |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Pop strobe |
| clr | input | 1 | Synchronous clear |
| pop_data | output | 8 | Registered popped byte, 8'hFF after a pop on an empty queue |
| level | output | 8 | Occupancy, 0 to capacity |
| empty | output | 1 | Occupancy is zero |
| nearly_full | output | 1 | Free space below the slack |

## Verification
The hardest case to reach is eviction while a pop happens in the same cycle at capacity. Getting there takes a full fill of the queue followed by overlapping strobes. The stimulus overfills the queue by twenty bytes and drains it to confirm exactly which bytes survived. It then refills and issues combined push and pop cycles at capacity. The flag boundary is approached one push at a time across the threshold, and pops on an empty queue are combined with pushes to cover the 8'hFF return path.

// File: rtl/obf_pkg.sv
package obf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } obf_req_t;

  function automatic logic [7:0] obf_void_byte();
    return 8'hFF;
  endfunction
endpackage

// File: rtl/obf_rst_sync.sv
module obf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      stage <= 1'b1;
      rst_q <= stage;
    end
  end
endmodule

// File: rtl/obf_ptr_ctl.sv
module obf_ptr_ctl #(
  parameter int DEPTH = 128,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  obf_pkg::obf_req_t req,
  output logic [PW-1:0]     wptr,
  output logic [PW-1:0]     rptr,
  output logic [CW-1:0]     count,
  output logic              wr_en,
  output logic              rd_req,
  output logic              rd_hit
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic          full, has_data, push_ok, pop_ok, evict, inc, en;
  logic [PW-1:0] wptr_n, rptr_n;
  logic [CW-1:0] count_n;

  always_comb begin
    full     = (count == CAP);
    has_data = (count != '0);
    push_ok  = req.push && !req.clr;
    pop_ok   = req.pop && has_data && !req.clr;
    evict    = push_ok && full && !pop_ok;
    inc      = push_ok && !evict;
    en       = req.clr || push_ok || pop_ok;
    if (req.clr) begin
      wptr_n  = '0;
      rptr_n  = '0;
      count_n = '0;
    end else begin
      wptr_n  = wptr + PW'(push_ok);
      rptr_n  = rptr + PW'(pop_ok || evict);
      count_n = count + CW'(inc) - CW'(pop_ok);
    end
  end

  assign wr_en  = push_ok;
  assign rd_req = req.pop && !req.clr;
  assign rd_hit = pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (en) begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= count_n;
    end
  end
endmodule

// File: rtl/obf_store.sv
module obf_store #(
  parameter int DEPTH = 128,
  parameter int W = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_req,
  input  logic          rd_hit,
  input  logic [PW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    rd_next = rd_hit ? mem[rd_addr] : {W{1'b1}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= {W{1'b1}};
    else if (rd_req) rd_data <= rd_next;
  end
endmodule

// File: rtl/obf_flags.sv
module obf_flags #(
  parameter int DEPTH = 128,
  parameter int SLACK = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] count,
  output logic          empty,
  output logic          nearly_full
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  assign empty = (count == '0);

  generate
    if (SLACK > 0) begin : g_slack
      localparam logic [CW-1:0] SL = CW'(SLACK);
      logic [CW-1:0] room;
      assign room        = CAP - count;
      assign nearly_full = (room < SL);
    end else begin : g_exact
      assign nearly_full = (count == CAP);
    end
  endgenerate
endmodule

// File: rtl/obf_byte_queue.sv
module obf_byte_queue #(
  parameter int DEPTH = 128,
  parameter int SLACK = 64,
  parameter int W = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic          clr,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          nearly_full
);
  generate
    if ((1 << PW) != DEPTH || SLACK >= DEPTH) begin : g_bad_cfg
      $error("DEPTH must be a power of two above SLACK");
    end
  endgenerate

  logic              rst_q;
  obf_pkg::obf_req_t req;
  logic [PW-1:0]     wptr, rptr;
  logic              wr_en, rd_req, rd_hit;

  assign req = '{push: push, pop: pop, clr: clr};

  obf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  obf_ptr_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_q), .req(req), .wptr(wptr), .rptr(rptr),
    .count(level), .wr_en(wr_en), .rd_req(rd_req), .rd_hit(rd_hit)
  );

  obf_store #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wptr),
    .wr_data(push_data), .rd_req(rd_req), .rd_hit(rd_hit),
    .rd_addr(rptr), .rd_data(pop_data)
  );

  obf_flags #(.DEPTH(DEPTH), .SLACK(SLACK)) u_flg (
    .count(level), .empty(empty), .nearly_full(nearly_full)
  );
endmodule

// File: rtl/obf_byte_queue_chk.sv
module obf_byte_queue_chk #(
  parameter int DEPTH = 128,
  parameter int W = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_q,
  input logic          push,
  input logic          pop,
  input logic          clr,
  input logic [W-1:0]  pop_data,
  input logic [CW-1:0] level,
  input logic          empty,
  input logic          nearly_full
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_q)
    (push && !pop && !clr && level < CAP) |=> level == $past(level) + 1'b1);

  a_r2_full_push_holds: assert property (@(posedge clk) disable iff (!rst_q)
    (push && !clr && level == CAP) |=> level == CAP);

  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_q)
    (pop && !push && !clr && level != '0) |=> level == $past(level) - 1'b1);

  a_r4_void_pop: assert property (@(posedge clk) disable iff (!rst_q)
    (pop && !clr && level == '0) |=> pop_data == {W{1'b1}});

  a_r5_both_steady: assert property (@(posedge clk) disable iff (!rst_q)
    (pop && push && !clr && level != '0) |=> $stable(level));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_q)
    clr |=> (level == '0 && $stable(pop_data)));

  a_r7_flag_rise: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(nearly_full) |-> level > $past(level));

  a_r8_empty_level: assert property (@(posedge clk) disable iff (!rst_q)
    (level != '0) |-> !empty);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !pop |=> $stable(pop_data));

  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_q)
    level <= CAP);
endmodule

bind obf_byte_queue obf_byte_queue_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_q(rst_q), .push(push), .pop(pop), .clr(clr),
  .pop_data(pop_data), .level(level), .empty(empty), .nearly_full(nearly_full)
);

// File: tb/sim_obf_byte_queue.sv
`timescale 1ns/1ps
module sim_obf_byte_queue;
  localparam int DEPTH = 128;
  localparam int SLACK = 64;

  logic       clk = 1'b0;
  logic       rst_n, push, pop, clr;
  logic [7:0] push_data, pop_data;
  logic [7:0] level;
  logic       empty, nearly_full;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] q[$];
  logic [7:0] exp_rd;

  always #2.5 clk = ~clk;

  obf_byte_queue #(.DEPTH(DEPTH), .SLACK(SLACK)) u0 (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .clr(clr), .pop_data(pop_data), .level(level),
    .empty(empty), .nearly_full(nearly_full)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "level", level, q.size());
    chk(tag, "pop_data", pop_data, exp_rd);
    chk({tag, "/R8"}, "empty", empty, q.size() == 0);
    chk({tag, "/R7"}, "nearly_full", nearly_full, (DEPTH - q.size()) < SLACK);
  endtask

  task automatic step(input logic pu, input logic [7:0] d, input logic po,
                      input logic cl, input string tag);
    push = pu; push_data = d; pop = po; clr = cl;
    @(posedge clk);
    if (cl) q.delete();
    else begin
      if (po) begin
        if (q.size() > 0) exp_rd = q.pop_front();
        else exp_rd = 8'hFF;
      end
      if (pu) begin
        if (q.size() == DEPTH) void'(q.pop_front());
        q.push_back(d);
      end
    end
    @(negedge clk);
    compare(tag);
    push = 0; pop = 0; clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; push = 0; pop = 0; clr = 0; push_data = 0;
    exp_rd = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare("R9");

    for (int i = 0; i < 10; i++) step(1, 8'(8'h30 + i), 0, 0, "R1");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, "R3");
    step(0, 0, 1, 0, "R4");
    step(0, 0, 0, 0, "R10");
    step(1, 8'h5A, 1, 0, "R4");
    step(0, 0, 0, 0, "R10");
    for (int i = 0; i < 6; i++) step(1, 8'(8'h70 + i), 1, 0, "R5");
    step(0, 0, 1, 0, "R3");
    step(0, 0, 1, 0, "R4");

    for (int i = 0; i < 70; i++) step(1, 8'(i), 0, 0, "R7");
    step(1, 8'hC1, 0, 1, "R6");
    step(0, 0, 1, 1, "R6");

    for (int i = 0; i < DEPTH + 20; i++) step(1, 8'(i), 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 8'(8'hE0 + i), 1, 0, "R5");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, "R2");
    step(0, 0, 1, 0, "R4");

    for (int i = 0; i < 300; i++)
      step(((i * 7) % 3) != 0, 8'(i * 13), ((i * 5) % 4) == 0, i == 250, "R3");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule